// File: doc/BRIEF.md
# Write-Allocate Decision Unit

For each write that misses the level-one data cache, this block decides whether the cache should fetch the line, so that the write can be merged into it (a write allocate). The caller raises a one-cycle request strobe with the write address. In the same cycle it presents the global cache controls, a per-page "do not cache" signal, the memory-type class of the address, the cache's sector-hit indication and a programmable address limit. One cycle later the block returns a valid strobe with a single allocate bit.

Three conditions can permit an allocate. The first is a page memory: a register that records the 4 KB page of the most recent cacheable read fill. The second is a sector hit, where the tag of a valid sector matches but the addressed line is missing. The third is a limit window: addresses below a programmable boundary, excluding the legacy 640 KB to 1 MB hole. Four inhibits take precedence over all of these. The page memory and the sector hit override the limit window and the legacy hole, but neither overrides an inhibit.

Top module: `wralloc_unit`

## Requirements
- R1: `decValid` is high exactly in the cycle after a cycle with `reqValid` high. `decAllocate` is low whenever `decValid` is low.
- R2: With `cacheDisable` high during the request, the decision is no-allocate.
- R3: With `pageNoCache` high during the request, the decision is no-allocate.
- R4: With the test-register `cacheInhibit` high during the request, the decision is no-allocate.
- R5: `memType` is 2'b00 write-back, 2'b01 write-through, 2'b10 uncacheable or 2'b11 write-combining. Either of the last two (bit 1 set) forces no-allocate. The first two do not block.
- R6: If the page memory is valid and `reqAddr[31:12]` equals its stored page, the decision is allocate.
- R7: When `fillValid` and `fillCacheable` are both high, the page memory loads `fillPage` (address bits 31:12) and becomes valid. Synchronous reset clears the memory. A request in the same cycle as a load compares against the value held before that load.
- R8: With `sectorHit` high, the decision is allocate.
- R9: When `limitUnits` is non-zero and `reqAddr[31:22]` is less than `limitUnits` (4 MB units), the decision is allocate. A `limitUnits` of zero turns this path off.
- R10: Addresses 0x000A_0000 to 0x000F_FFFF never allocate through the limit path.
- R11: A page match or a sector hit allocates even inside the legacy hole or above the limit, but never against any of the inhibits in R2 to R5.
- R12: When no page match, no sector hit and no permitted limit case applies, the decision is no-allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Write-miss request strobe |
| reqAddr | input | 32 | Write address |
| cacheDisable | input | 1 | Global cache-disable control bit |
| cacheInhibit | input | 1 | Test-register cache-inhibit bit |
| pageNoCache | input | 1 | Page-level cache disable for this access |
| memType | input | 2 | Memory type class of reqAddr (encoding in R5) |
| sectorHit | input | 1 | Valid sector tag matches, addressed line absent |
| limitUnits | input | 7 | Allocate limit in 4 MB units, 0 = off |
| fillValid | input | 1 | A read fill completes this cycle |
| fillCacheable | input | 1 | That read fill was cacheable |
| fillPage | input | 20 | Page address (bits 31:12) of the read fill |
| decValid | output | 1 | Decision strobe |
| decAllocate | output | 1 | 1 = start a line fill for the write |

## Verification
The page-memory load and the allocate decision can happen in the same cycle: a cacheable read fill can complete on the same edge as a write-miss request. The bench provokes this by driving a fill for one page and a request to that same page in one cycle. The expected result is no-allocate, because the old page is compared. A request on the following cycle must then allocate. A second collision drives a fill while an inhibit is raised, and checks that the loaded page still cannot override the inhibit.

// File: rtl/wralloc_pkg.sv
package wralloc_pkg;
  typedef struct packed {
    logic capture;    // evaluate and register a decision
    logic loadPage;   // write fill page into page memory
    logic clearPage;  // invalidate page memory
  } waStrobe_t;
endpackage

// File: rtl/wralloc_ctrl.sv
module wralloc_ctrl
  import wralloc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      fillValid,
  input  logic      fillCacheable,
  output waStrobe_t strobes,
  output logic      decValid
);
  always_comb begin
    strobes.clearPage = rst;
    strobes.capture   = reqValid && !rst;
    strobes.loadPage  = fillValid && fillCacheable && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) decValid <= 1'b0;
    else     decValid <= reqValid;
  end

  // R1: a decision strobe follows every request
  p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> decValid);
  // R1: no decision strobe without a request
  p_valid_only_after_req_r1: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !decValid);
endmodule

// File: rtl/wralloc_dp.sv
module wralloc_dp
  import wralloc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int LIMIT_W   = 7,
  parameter int LIMIT_LSB = 22,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h000F_FFFF
)(
  input  logic                     clk,
  input  logic                     rst,
  input  waStrobe_t                strobes,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     cacheDisable,
  input  logic                     cacheInhibit,
  input  logic                     pageNoCache,
  input  logic [1:0]               memType,
  input  logic                     sectorHit,
  input  logic [LIMIT_W-1:0]       limitUnits,
  input  logic [ADDR_W-1:PAGE_LSB] fillPage,
  output logic                     decAllocate
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int REGION_W = ADDR_W - LIMIT_LSB;
  localparam int PAD_W = REGION_W - LIMIT_W;

  logic [PAGE_W-1:0] pageReg;
  logic              pageValid;
  logic              pageHit, inHole, belowLimit, blocked, allowNext, allocQ;

  always_ff @(posedge clk) begin
    if (strobes.clearPage) begin
      pageReg   <= '0;
      pageValid <= 1'b0;
    end else if (strobes.loadPage) begin
      pageReg   <= fillPage;
      pageValid <= 1'b1;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign belowLimit = (limitUnits != '0) &&
        ({{PAD_W{1'b0}}, limitUnits} > reqAddr[ADDR_W-1:LIMIT_LSB]);
    end else begin : g_nopad
      assign belowLimit = (limitUnits != '0) &&
        (limitUnits[REGION_W-1:0] > reqAddr[ADDR_W-1:LIMIT_LSB]);
    end
  endgenerate

  always_comb begin
    pageHit   = pageValid && (reqAddr[ADDR_W-1:PAGE_LSB] == pageReg);
    inHole    = (reqAddr >= HOLE_LO) && (reqAddr <= HOLE_HI);
    blocked   = cacheDisable || cacheInhibit || pageNoCache || memType[1];
    allowNext = !blocked && (pageHit || sectorHit || (belowLimit && !inHole));
  end

  always_ff @(posedge clk) begin
    if (rst) allocQ <= 1'b0;
    else     allocQ <= strobes.capture && allowNext;
  end

  assign decAllocate = allocQ;

  // R2
  p_cd_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && cacheDisable) |=> !allocQ);
  // R3
  p_pcd_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && pageNoCache) |=> !allocQ);
  // R4
  p_inhibit_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && cacheInhibit) |=> !allocQ);
  // R5
  p_memtype_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && memType[1]) |=> !allocQ);
  // R11: sector hit wins whenever no inhibit is present
  p_sector_override_r11: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && sectorHit && !cacheDisable && !cacheInhibit &&
     !pageNoCache && !memType[1]) |=> allocQ);
  // R10: the hole never allocates without page or sector help
  p_hole_excluded_r10: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && inHole && !sectorHit && !pageHit) |=> !allocQ);
  // R1
  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> !allocQ);
endmodule

// File: rtl/wralloc_unit.sv
module wralloc_unit
  import wralloc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int LIMIT_W   = 7,
  parameter int LIMIT_LSB = 22
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     cacheDisable,
  input  logic                     cacheInhibit,
  input  logic                     pageNoCache,
  input  logic [1:0]               memType,
  input  logic                     sectorHit,
  input  logic [LIMIT_W-1:0]       limitUnits,
  input  logic                     fillValid,
  input  logic                     fillCacheable,
  input  logic [ADDR_W-1:PAGE_LSB] fillPage,
  output logic                     decValid,
  output logic                     decAllocate
);
  waStrobe_t strobes;

  wralloc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .fillValid(fillValid),
    .fillCacheable(fillCacheable), .strobes(strobes), .decValid(decValid)
  );

  wralloc_dp #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .LIMIT_W(LIMIT_W), .LIMIT_LSB(LIMIT_LSB)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .reqAddr(reqAddr),
    .cacheDisable(cacheDisable), .cacheInhibit(cacheInhibit),
    .pageNoCache(pageNoCache), .memType(memType), .sectorHit(sectorHit),
    .limitUnits(limitUnits), .fillPage(fillPage), .decAllocate(decAllocate)
  );
endmodule

// File: tb/wralloc_unit_bench.sv
module wralloc_unit_bench;
  logic clk = 0;
  logic rst = 1;
  logic reqValid = 0;
  logic [31:0] reqAddr = '0;
  logic cacheDisable = 0, cacheInhibit = 0, pageNoCache = 0;
  logic [1:0] memType = 2'b00;
  logic sectorHit = 0;
  logic [6:0] limitUnits = '0;
  logic fillValid = 0, fillCacheable = 0;
  logic [19:0] fillPage = '0;
  logic decValid, decAllocate;

  int compared = 0, mismatched = 0;
  logic expQ[$];
  string tagQ[$];
  logic [19:0] modelPage = '0;
  logic modelValid = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  wralloc_unit u_wralloc_unit (.*);

  function automatic logic expect_alloc(logic [31:0] a, logic cd, logic ci,
      logic pcd, logic [1:0] mt, logic sh, logic [6:0] lim);
    logic pg, lm, hole;
    pg   = modelValid && (a[31:12] == modelPage);
    hole = (a >= 32'h000A_0000) && (a <= 32'h000F_FFFF);
    lm   = (lim != 0) && ({3'b000, lim} > a[31:22]) && !hole;
    return !(cd || ci || pcd || mt[1]) && (pg || sh || lm);
  endfunction

  task automatic do_req(input logic [31:0] a, input logic cd, ci, pcd,
      input logic [1:0] mt, input logic sh, input logic [6:0] lim,
      input string tag, input bit withFill = 0, input logic [19:0] fp = '0);
    @(negedge clk);
    reqValid = 1; reqAddr = a; cacheDisable = cd; cacheInhibit = ci;
    pageNoCache = pcd; memType = mt; sectorHit = sh; limitUnits = lim;
    expQ.push_back(expect_alloc(a, cd, ci, pcd, mt, sh, lim));
    tagQ.push_back(tag);
    if (withFill) begin
      fillValid = 1; fillCacheable = 1; fillPage = fp;
      modelPage = fp; modelValid = 1;
    end
    @(negedge clk);
    reqValid = 0; fillValid = 0; fillCacheable = 0;
    cacheDisable = 0; cacheInhibit = 0; pageNoCache = 0; memType = 0;
    sectorHit = 0;
  endtask

  task automatic do_fill(input logic [19:0] fp, input logic cacheable);
    @(negedge clk);
    fillValid = 1; fillCacheable = cacheable; fillPage = fp;
    if (cacheable) begin modelPage = fp; modelValid = 1; end
    @(negedge clk);
    fillValid = 0; fillCacheable = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (decValid) begin
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R1: unexpected decValid, actual 1 expected 0");
        end else begin
          logic e; string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          if (decAllocate !== e) begin
            mismatched++;
            $display("FAIL %s: decAllocate actual %0b expected %0b", t, decAllocate, e);
          end
        end
      end else if (decAllocate !== 1'b0) begin
        compared++; mismatched++;
        $display("FAIL R1: decAllocate actual %0b expected 0 while idle", decAllocate);
      end
    end
  end

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compared++;
    if (decValid !== 0 || decAllocate !== 0) begin
      mismatched++;
      $display("FAIL R1: reset outputs actual %0b%0b expected 00", decValid, decAllocate);
    end
    // R12: nothing enables, cleared page memory
    do_req(32'h1234_5000, 0,0,0,2'b00, 0, 7'd0, "R12");
    // R9: limit path
    do_req(32'h0040_0000, 0,0,0,2'b00, 0, 7'd2, "R9");
    do_req(32'h0080_0000, 0,0,0,2'b00, 0, 7'd2, "R9");
    do_req(32'h0000_1000, 0,0,0,2'b00, 0, 7'd0, "R9");
    do_req(32'h1F00_0000, 0,0,0,2'b01, 0, 7'd127, "R9");
    // R10: legacy hole edges
    do_req(32'h0009_FFFF, 0,0,0,2'b00, 0, 7'd1, "R10");
    do_req(32'h000A_0000, 0,0,0,2'b00, 0, 7'd1, "R10");
    do_req(32'h000F_FFFF, 0,0,0,2'b00, 0, 7'd1, "R10");
    do_req(32'h0010_0000, 0,0,0,2'b00, 0, 7'd1, "R10");
    // R8 and R11 sector hit
    do_req(32'h3000_0000, 0,0,0,2'b00, 1, 7'd0, "R8");
    do_req(32'h000B_0000, 0,0,0,2'b00, 1, 7'd1, "R11");
    // R2..R5 inhibits against everything else
    do_req(32'h0040_0000, 1,0,0,2'b00, 1, 7'd2, "R2");
    do_req(32'h0040_0000, 0,0,1,2'b00, 1, 7'd2, "R3");
    do_req(32'h0040_0000, 0,1,0,2'b00, 1, 7'd2, "R4");
    do_req(32'h0040_0000, 0,0,0,2'b10, 1, 7'd2, "R5");
    do_req(32'h0040_0000, 0,0,0,2'b11, 1, 7'd2, "R5");
    do_req(32'h0040_0000, 0,0,0,2'b01, 1, 7'd0, "R5");
    // R6 / R7 page memory
    do_fill(20'h7777_7, 1'b1);
    do_req(32'h7777_7ABC, 0,0,0,2'b00, 0, 7'd0, "R6");
    do_req(32'h7777_8000, 0,0,0,2'b00, 0, 7'd0, "R6");
    do_fill(20'h000C_0, 1'b1);
    do_req(32'h000C_0010, 0,0,0,2'b00, 0, 7'd1, "R11");
    do_req(32'h000C_0010, 0,0,0,2'b10, 0, 7'd1, "R11");
    do_fill(20'h5555_5, 1'b0);  // non-cacheable fill does not load
    do_req(32'h5555_5000, 0,0,0,2'b00, 0, 7'd0, "R7");
    do_req(32'h000C_0FFF, 0,0,0,2'b00, 0, 7'd0, "R7");
    // R7 collision: fill and request in the same cycle see the old page
    do_req(32'h4444_4000, 0,0,0,2'b00, 0, 7'd0, "R7", 1, 20'h4444_4);
    do_req(32'h4444_4008, 0,0,0,2'b00, 0, 7'd0, "R7");
    do_req(32'h2222_2000, 1,0,0,2'b00, 0, 7'd0, "R2", 1, 20'h2222_2);
    do_req(32'h2222_2000, 0,0,1,2'b00, 0, 7'd0, "R3");
    // R7 reset clears page memory
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    modelValid = 0; modelPage = '0;
    do_req(32'h2222_2000, 0,0,0,2'b00, 0, 7'd0, "R7");
    do_req(32'h0000_0000, 0,0,0,2'b00, 0, 7'd0, "R7");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R1: %0d decisions missing, expected 0", expQ.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule